// File: doc/BRIEF.md
# MSI-X Interrupt Message Generator

This block converts interrupt requests into single-dword posted memory-write packets on a 64-bit transmit stream. The stream has data, valid, ready, start-of-packet and end-of-packet signals. Each request names a vector and sets that vector's pending flag. When a pending vector is allowed to signal, the block picks it and reads the vector's message address and data from an external table through a read port with one cycle of latency. It then emits the packet, holding each beat until the sink accepts it.

A vector is allowed to signal only in one case. The enable bit of the captured control word must be set, the function-wide mask bit must be clear, and the vector's own mask input must be clear. A request that arrives while it is not allowed stays pending and goes out by itself once the conditions change. The header is three dwords when the upper address half is zero and four dwords when it is not. Address bit 2 decides which half of a beat carries the payload. Only one message is in flight at a time.

Top module: `msix_msg_gen`

## Requirements
- R1: After reset, tx_valid and tbl_rd_en are low and no vector is pending.
- R2: While msix_ctrl[15] (enable) is 0, no message starts. A request made meanwhile stays pending and is sent once the enable bit is set.
- R3: While msix_ctrl[14] (function mask) is 1, all vectors are held back. While it is 0, a vector is held back only when its vec_mask bit is 1. A held-back request is sent after the mask is released.
- R4: Beat 0 is {req_id, 8'h00, 8'h0F, fmt, 14'b0, 10'd1}. The low half carries the format/type byte in [31:24] and a length of 1. The high half carries the requester ID, tag 0, last byte enable 0 and first byte enable F. tx_sop is high on beat 0 only.
- R5: fmt is 8'h40 (three-dword header) when table address [63:32] is zero, and 8'h60 (four-dword header) otherwise. With the four-dword header, beat 1 is {lower address, upper address}.
- R6: With the three-dword header and address bit 2 = 1, the packet has two beats. Beat 1 is {data, lower address}, and tx_eop is high on beat 1.
- R7: With the three-dword header and address bit 2 = 0, the packet has three beats. Beat 1 is {32'h0, lower address}, beat 2 is {32'h0, data}, and tx_eop is high on beat 2.
- R8: With the four-dword header, beat 2 is the last beat. It carries the data in its low half when address bit 2 = 0 and in its high half when bit 2 = 1, with the other half zero.
- R9: Address bits [1:0] are sent as zero whatever the table holds.
- R10: While tx_valid is high and tx_ready is low, tx_data, tx_sop and tx_eop hold their values.
- R11: Among eligible pending vectors, the lowest-numbered one is sent first. Repeated requests for a vector that is already pending merge into one message.
- R12: A table read is a one-cycle tbl_rd_en pulse with tbl_rd_idx set to the chosen vector. The table answers in the next cycle. No beat is valid during a read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_valid | input | 1 | Interrupt request strobe |
| irq_vec | input | VEC_W | Vector of the request |
| msix_ctrl | input | 16 | Captured control word; bit 15 enable, bit 14 function mask |
| vec_mask | input | NUM_VEC | Per-vector mask bits, 1 = masked |
| req_id | input | 16 | Requester ID placed in the header |
| tbl_rd_en | output | 1 | Table read strobe |
| tbl_rd_idx | output | VEC_W | Vector being read |
| tbl_addr | input | 64 | Message address returned one cycle after the read |
| tbl_data | input | 32 | Message data returned one cycle after the read |
| tx_data | output | 64 | Transmit beat |
| tx_valid | output | 1 | Beat valid |
| tx_ready | input | 1 | Sink accepts the beat |
| tx_sop | output | 1 | First beat of packet |
| tx_eop | output | 1 | Last beat of packet |

## Verification
The bench builds the block with NUM_VEC = 8. It uses table entries whose upper half is either zero or non-zero and whose address bit 2 is either set or clear. This reaches all four beat layouts, plus an entry whose low address bits are nonzero. Eight vectors give room to queue several masked requests at spread-out indices, so the lowest-index ordering and the merging of repeated requests can both be seen. The sink's ready toggles in a pseudo-random pattern during part of the run, so beats are held across stalls.

// File: rtl/msix_pkg.sv
package msix_pkg;

    localparam logic [7:0] FT_MWR_3DW = 8'h40;
    localparam logic [7:0] FT_MWR_4DW = 8'h60;
    localparam int CTRL_EN_BIT    = 15;
    localparam int CTRL_FMASK_BIT = 14;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_FETCH,
        ST_LOAD,
        ST_SEND
    } gen_state_e;

    typedef struct packed {
        logic [31:0] addr_hi;
        logic [31:0] addr_lo;
        logic [31:0] data;
    } msix_entry_t;

    function automatic logic [63:0] make_beat0(input logic wide, input logic [15:0] rid);
        logic [31:0] dw0;
        logic [31:0] dw1;
        dw0 = {(wide ? FT_MWR_4DW : FT_MWR_3DW), 14'b0, 10'd1};
        dw1 = {rid, 8'h00, 4'h0, 4'hF};
        return {dw1, dw0};
    endfunction

endpackage

// File: rtl/msix_pending.sv
module msix_pending
    import msix_pkg::*;
#(
    parameter int NUM_VEC = 8,
    parameter int VEC_W   = 3
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               req_valid,
    input  logic [VEC_W-1:0]   req_vec,
    input  logic               allow,
    input  logic [NUM_VEC-1:0] vec_mask,
    input  logic               take,
    output logic               any_ready,
    output logic [VEC_W-1:0]   pick_idx
);

    logic [NUM_VEC-1:0] pend;
    logic [NUM_VEC-1:0] ready_vec;

    for (genvar g = 0; g < NUM_VEC; g++) begin : g_pend
        logic bit_q;
        logic hit_set;
        logic hit_clr;
        assign hit_set = req_valid && (req_vec == VEC_W'(g));
        assign hit_clr = take && (pick_idx == VEC_W'(g));
        always_ff @(posedge clk) begin
            if (rst)
                bit_q <= 1'b0;
            else if (hit_set)
                bit_q <= 1'b1;
            else if (hit_clr)
                bit_q <= 1'b0;
        end
        assign pend[g] = bit_q;
    end

    assign ready_vec = pend & ~vec_mask & {NUM_VEC{allow}};
    assign any_ready = |ready_vec;

    always_comb begin
        pick_idx = '0;
        for (int i = NUM_VEC - 1; i >= 0; i--) begin
            if (ready_vec[i])
                pick_idx = VEC_W'(i);
        end
    end

endmodule

// File: rtl/msix_beat_build.sv
module msix_beat_build
    import msix_pkg::*;
(
    input  msix_entry_t entry,
    input  logic [15:0] rid,
    input  logic [1:0]  beat,
    output logic [63:0] data,
    output logic        last
);

    logic wide;
    logic odd_dw;

    assign wide   = |entry.addr_hi;
    assign odd_dw = entry.addr_lo[2];

    always_comb begin
        data = '0;
        last = 1'b0;
        case (beat)
            2'd0: data = make_beat0(wide, rid);
            2'd1: begin
                if (wide)
                    data = {entry.addr_lo, entry.addr_hi};
                else if (odd_dw)
                    data = {entry.data, entry.addr_lo};
                else
                    data = {32'h0, entry.addr_lo};
                last = !wide && odd_dw;
            end
            2'd2: begin
                data = odd_dw ? {entry.data, 32'h0} : {32'h0, entry.data};
                last = 1'b1;
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/msix_msg_gen.sv
module msix_msg_gen
    import msix_pkg::*;
#(
    parameter int NUM_VEC = 8,
    localparam int VEC_W  = (NUM_VEC > 1) ? $clog2(NUM_VEC) : 1
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               irq_valid,
    input  logic [VEC_W-1:0]   irq_vec,
    input  logic [15:0]        msix_ctrl,
    input  logic [NUM_VEC-1:0] vec_mask,
    input  logic [15:0]        req_id,
    output logic               tbl_rd_en,
    output logic [VEC_W-1:0]   tbl_rd_idx,
    input  logic [63:0]        tbl_addr,
    input  logic [31:0]        tbl_data,
    output logic [63:0]        tx_data,
    output logic               tx_valid,
    input  logic               tx_ready,
    output logic               tx_sop,
    output logic               tx_eop
);

    gen_state_e  state;
    logic [1:0]  beat;
    logic [VEC_W-1:0] sel;
    msix_entry_t entry;
    logic        allow;
    logic        any_ready;
    logic [VEC_W-1:0] pick_idx;
    logic        take;
    logic [63:0] beat_data;
    logic        beat_last;
    logic        unused_bits;

    assign unused_bits = ^{msix_ctrl[13:0], tbl_addr[1:0]};
    assign allow = msix_ctrl[CTRL_EN_BIT] && !msix_ctrl[CTRL_FMASK_BIT];
    assign take  = (state == ST_IDLE) && any_ready;

    msix_pending #(.NUM_VEC(NUM_VEC), .VEC_W(VEC_W)) u_pend (
        .clk      (clk),
        .rst      (rst),
        .req_valid(irq_valid),
        .req_vec  (irq_vec),
        .allow    (allow),
        .vec_mask (vec_mask),
        .take     (take),
        .any_ready(any_ready),
        .pick_idx (pick_idx)
    );

    msix_beat_build u_build (
        .entry(entry),
        .rid  (req_id),
        .beat (beat),
        .data (beat_data),
        .last (beat_last)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_IDLE;
            beat  <= '0;
            sel   <= '0;
            entry <= '0;
        end else begin
            case (state)
                ST_IDLE: if (any_ready) begin
                    sel   <= pick_idx;
                    state <= ST_FETCH;
                end
                ST_FETCH: state <= ST_LOAD;
                ST_LOAD: begin
                    entry <= '{addr_hi: tbl_addr[63:32],
                               addr_lo: {tbl_addr[31:2], 2'b00},
                               data:    tbl_data};
                    beat  <= '0;
                    state <= ST_SEND;
                end
                ST_SEND: if (tx_ready) begin
                    if (beat_last)
                        state <= ST_IDLE;
                    else
                        beat <= beat + 2'd1;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    assign tbl_rd_en  = (state == ST_FETCH);
    assign tbl_rd_idx = sel;
    assign tx_valid   = (state == ST_SEND);
    assign tx_sop     = tx_valid && (beat == 2'd0);
    assign tx_eop     = tx_valid && beat_last;
    assign tx_data    = tx_valid ? beat_data : 64'h0;

endmodule

// File: rtl/msix_msg_gen_chk.sv
module msix_msg_gen_chk (
    input logic        clk,
    input logic        rst,
    input logic [15:0] msix_ctrl,
    input logic        tbl_rd_en,
    input logic [63:0] tx_data,
    input logic        tx_valid,
    input logic        tx_ready,
    input logic        tx_sop,
    input logic        tx_eop
);

    // R10
    beat_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_data) && $stable(tx_sop) && $stable(tx_eop)));

    // R4
    sop_once_chk: assert property (@(posedge clk) disable iff (rst)
        (tx_valid && tx_sop && tx_ready) |=> (tx_valid && !tx_sop));

    // R6
    eop_not_first_chk: assert property (@(posedge clk) disable iff (rst)
        tx_eop |-> !tx_sop);

    // R2
    launch_enabled_chk: assert property (@(posedge clk) disable iff (rst)
        tbl_rd_en |-> ($past(msix_ctrl[15]) && !$past(msix_ctrl[14])));

    // R12
    read_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        tbl_rd_en |=> !tbl_rd_en);

    // R12
    read_idle_tx_chk: assert property (@(posedge clk) disable iff (rst)
        tbl_rd_en |-> !tx_valid);

endmodule

bind msix_msg_gen msix_msg_gen_chk u_chk (
    .clk      (clk),
    .rst      (rst),
    .msix_ctrl(msix_ctrl),
    .tbl_rd_en(tbl_rd_en),
    .tx_data  (tx_data),
    .tx_valid (tx_valid),
    .tx_ready (tx_ready),
    .tx_sop   (tx_sop),
    .tx_eop   (tx_eop)
);

// File: tb/msix_msg_gen_tb.sv
module msix_msg_gen_tb;

    localparam int NV = 8;
    localparam int VW = 3;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          irq_valid = 1'b0;
    logic [VW-1:0] irq_vec = '0;
    logic [15:0]   msix_ctrl = 16'h0000;
    logic [NV-1:0] vec_mask = '0;
    logic [15:0]   req_id = 16'hBEEF;
    logic          tbl_rd_en;
    logic [VW-1:0] tbl_rd_idx;
    logic [63:0]   tbl_addr;
    logic [31:0]   tbl_data;
    logic [63:0]   tx_data;
    logic          tx_valid;
    logic          tx_ready = 1'b1;
    logic          tx_sop;
    logic          tx_eop;

    int errors = 0;
    int checks = 0;
    bit finished = 0;
    bit rdy_toggle = 0;
    logic [15:0] lfsr = 16'hACE1;

    logic [63:0] t_addr [NV];
    logic [31:0] t_data [NV];
    logic [VW-1:0] rd_q = '0;

    always #10 clk = ~clk;

    msix_msg_gen #(.NUM_VEC(NV)) u_dut (
        .clk(clk), .rst(rst), .irq_valid(irq_valid), .irq_vec(irq_vec),
        .msix_ctrl(msix_ctrl), .vec_mask(vec_mask), .req_id(req_id),
        .tbl_rd_en(tbl_rd_en), .tbl_rd_idx(tbl_rd_idx),
        .tbl_addr(tbl_addr), .tbl_data(tbl_data),
        .tx_data(tx_data), .tx_valid(tx_valid), .tx_ready(tx_ready),
        .tx_sop(tx_sop), .tx_eop(tx_eop)
    );

    // table with one cycle of read latency
    always @(posedge clk) if (tbl_rd_en) rd_q <= tbl_rd_idx;
    assign tbl_addr = t_addr[rd_q];
    assign tbl_data = t_data[rd_q];

    // sink ready pattern
    always @(posedge clk) begin
        #5;
        lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        tx_ready = rdy_toggle ? lfsr[0] : 1'b1;
    end

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // ---------------- behavioural reference model ----------------
    int m_phase = 0;
    int m_sel = 0;
    bit [NV-1:0] m_pend = '0;
    logic [65:0] m_q [$];

    task automatic model_build(input int v);
        logic [31:0] dw [$];
        logic [31:0] hi;
        logic [31:0] lo;
        hi = t_addr[v][63:32];
        lo = {t_addr[v][31:2], 2'b00};
        dw.push_back({(hi == 0) ? 8'h40 : 8'h60, 14'b0, 10'd1});
        dw.push_back({req_id, 8'h00, 8'h0F});
        if (hi != 0) dw.push_back(hi);
        dw.push_back(lo);
        if ((dw.size() % 2) != int'(lo[2])) dw.push_back(32'h0);
        dw.push_back(t_data[v]);
        if ((dw.size() % 2) == 1) dw.push_back(32'h0);
        for (int k = 0; k < dw.size(); k += 2)
            m_q.push_back({k == 0, k + 2 == dw.size(), dw[k + 1], dw[k]});
    endtask

    always @(posedge clk) begin
        int nphase;
        bit [NV-1:0] clr;
        bit found;
        if (rst) begin
            m_phase = 0;
            m_pend = '0;
            m_q.delete();
        end else begin
            nphase = m_phase;
            clr = '0;
            found = 0;
            case (m_phase)
                0: if (msix_ctrl[15] && !msix_ctrl[14]) begin
                    for (int i = 0; i < NV; i++)
                        if (!found && m_pend[i] && !vec_mask[i]) begin
                            found = 1;
                            m_sel = i;
                        end
                    if (found) begin
                        clr[m_sel] = 1'b1;
                        nphase = 1;
                    end
                end
                1: nphase = 2;
                2: begin model_build(m_sel); nphase = 3; end
                default: if (tx_ready) begin
                    void'(m_q.pop_front());
                    if (m_q.size() == 0) nphase = 0;
                end
            endcase
            m_pend = m_pend & ~clr;
            if (irq_valid) m_pend[irq_vec] = 1'b1;
            m_phase = nphase;
        end
    end

    // per-cycle comparison and capture of accepted beats
    logic [65:0] cap [$];
    always @(negedge clk) begin
        if (!rst && !finished) begin
            check("R10 valid", {63'h0, tx_valid}, {63'h0, m_phase == 3});
            if (m_phase == 3 && tx_valid && m_q.size() > 0)
                check("R10 beat", {tx_sop, tx_eop, tx_data}, m_q[0]);
            check("R12 rd_en", {63'h0, tbl_rd_en}, {63'h0, m_phase == 1});
            if (m_phase == 1)
                check("R12 rd_idx", {61'h0, tbl_rd_idx}, 64'(m_sel));
            if (tx_valid && tx_ready) cap.push_back({tx_sop, tx_eop, tx_data});
        end
    end

    task automatic tick(input int n);
        repeat (n) @(posedge clk);
        #5;
    endtask

    task automatic irq(input int v);
        irq_valid = 1'b1;
        irq_vec = VW'(v);
        tick(1);
        irq_valid = 1'b0;
    endtask

    function automatic logic [63:0] hdr0(input logic [7:0] ft);
        return {req_id, 8'h00, 8'h0F, ft, 14'b0, 10'd1};
    endfunction

    // watchdog
    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            errors++;
            checks++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < NV; i++) begin
            t_addr[i] = {32'h0, 32'h0000_1004 + 32'(i * 16)};
            t_data[i] = 32'hD000_0000 | 32'(i);
        end
        tick(3);
        rst = 1'b0;
        #5;
        check("R1 tx_valid", {63'h0, tx_valid}, 64'h0);
        check("R1 rd_en", {63'h0, tbl_rd_en}, 64'h0);
        tick(5);
        check("R1 no pending", 64'(cap.size()), 64'h0);

        // three-dword header, address bit 2 set
        msix_ctrl = 16'h8000;
        cap.delete();
        irq(3);
        tick(15);
        check("R6 beats", 64'(cap.size()), 64'd2);
        if (cap.size() == 2) begin
            check("R4 beat0", cap[0][63:0], hdr0(8'h40));
            check("R4 sop", {62'h0, cap[0][65:64]}, 64'h2);
            check("R5 fmt3dw", 64'(cap[0][31:24]), 64'h40);
            check("R6 beat1", cap[1][63:0], {t_data[3], t_addr[3][31:0]});
            check("R6 eop", {62'h0, cap[1][65:64]}, 64'h1);
        end

        // three-dword header, address bit 2 clear
        t_addr[2] = {32'h0, 32'h0000_2008};
        cap.delete();
        irq(2);
        tick(15);
        check("R7 beats", 64'(cap.size()), 64'd3);
        if (cap.size() == 3) begin
            check("R7 beat1", cap[1][63:0], {32'h0, 32'h0000_2008});
            check("R7 beat2", cap[2][63:0], {32'h0, t_data[2]});
            check("R7 eop", {62'h0, cap[2][65:64]}, 64'h1);
        end

        // four-dword header, bit 2 clear
        t_addr[5] = {32'h0000_0001, 32'h0000_3000};
        cap.delete();
        irq(5);
        tick(15);
        check("R8 beats", 64'(cap.size()), 64'd3);
        if (cap.size() == 3) begin
            check("R5 fmt4dw", cap[0][63:0], hdr0(8'h60));
            check("R5 beat1", cap[1][63:0], {32'h0000_3000, 32'h0000_0001});
            check("R8 low data", cap[2][63:0], {32'h0, t_data[5]});
        end

        // four-dword header, bit 2 set, stray low address bits
        t_addr[6] = 64'hFFFF_FFFF_FFF0_F00F;
        cap.delete();
        irq(6);
        tick(15);
        check("R8 beats hi", 64'(cap.size()), 64'd3);
        if (cap.size() == 3) begin
            check("R9 addr lsbs", cap[1][63:0], {32'hFFF0_F00C, 32'hFFFF_FFFF});
            check("R8 high data", cap[2][63:0], {t_data[6], 32'h0});
        end

        // stalls from the sink
        rdy_toggle = 1;
        cap.delete();
        irq(5);
        tick(60);
        irq(2);
        tick(60);
        rdy_toggle = 0;
        tick(5);
        check("R10 stalled beats", 64'(cap.size()), 64'd6);

        // enable bit off
        msix_ctrl = 16'h0000;
        cap.delete();
        irq(1);
        tick(20);
        check("R2 held while disabled", 64'(cap.size()), 64'd0);
        msix_ctrl = 16'h8000;
        tick(15);
        check("R2 sent after enable", 64'(cap.size()), 64'd2);
        if (cap.size() == 2) check("R2 data", 64'(cap[1][63:32]), 64'(t_data[1]));

        // function mask and vector mask
        msix_ctrl = 16'hC000;
        cap.delete();
        irq(0);
        tick(20);
        check("R3 function mask", 64'(cap.size()), 64'd0);
        vec_mask = 8'h01;
        msix_ctrl = 16'h8000;
        tick(20);
        check("R3 vector mask", 64'(cap.size()), 64'd0);
        vec_mask = 8'h00;
        tick(15);
        check("R3 sent after unmask", 64'(cap.size()), 64'd2);

        // ordering and merging
        vec_mask = 8'hFF;
        cap.delete();
        irq(4);
        irq(1);
        irq(1);
        irq(4);
        tick(10);
        check("R11 nothing while masked", 64'(cap.size()), 64'd0);
        vec_mask = 8'h00;
        tick(30);
        check("R11 two messages", 64'(cap.size()), 64'd4);
        if (cap.size() == 4) begin
            check("R11 first vec1", 64'(cap[1][63:32]), 64'(t_data[1]));
            check("R11 second vec4", 64'(cap[3][63:32]), 64'(t_data[4]));
        end

        finished = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule